// File: doc/BRIEF.md
# Link Reset Sequencer

This controller brings a serial link's reset domains out of reset in a fixed order once the device reports that configuration has finished. It drives four active-high resets: the management reset of the transceiver reconfiguration logic, the endpoint reset, the root-port reset and the application-layer reset. It starts releasing them when the configuration-done input rises. Release of the endpoint reset is gated two ways. A minimum delay must have passed since configuration done. The transmit and receive calibration-busy flags must both have cleared. A second, much longer delay then separates the root-port release from the endpoint release.

Both delays are counted in clock cycles by one shared counter. The default terminal counts are derived from the clock frequency: one millisecond for the endpoint and one hundred milliseconds for the root port. A testbench may override them with short values. The three status inputs are asynchronous to the clock and pass through two-flop synchronizers before the state machine uses them. Releases are sticky until a full restart, which is caused by configuration done falling or by the asynchronous reset. A done flag and the current state are reported once the application layer has been let go.

Top module: `link_reset_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises until configuration done is seen, all four resets are high, `seq_done_o` is 0 and `seq_state_o` reads 0 (idle).
- R2: The management reset falls first, 3 clock edges after `cfg_done_i` rises (two synchronizer stages plus the state register). No other output changes on that edge.
- R3: The endpoint reset stays high while either `tx_cal_busy_i` or `rx_cal_busy_i` is high. If the delay has already elapsed, it falls 3 edges after the later of the two busy flags falls.
- R4: With both busy flags low, the endpoint reset falls exactly `EP_WAIT_CYC`+4 edges after `cfg_done_i` rises. `EP_WAIT_CYC` defaults to `CLK_FREQ_HZ`/1000.
- R5: The root-port reset falls exactly `RP_WAIT_CYC`+1 edges after the endpoint reset falls. `RP_WAIT_CYC` defaults to `CLK_FREQ_HZ`/10.
- R6: The application reset falls one edge after the root-port reset. On that same edge `seq_done_o` rises and `seq_state_o` reads 4 (running).
- R7: If `cfg_done_i` falls in any state, all four resets reassert and `seq_state_o` reads 0, 3 edges later. A new rising edge restarts the whole sequence, including the endpoint delay.
- R8: Driving `rst_n` low reasserts all four resets and clears `seq_done_o` at once, without waiting for a clock edge.
- R9: Once the endpoint reset is released, later activity on either calibration-busy input has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| cfg_done_i | input | 1 | Device configuration complete (asynchronous) |
| tx_cal_busy_i | input | 1 | Transmit calibration in progress (asynchronous) |
| rx_cal_busy_i | input | 1 | Receive calibration in progress (asynchronous) |
| mgmt_rst_o | output | 1 | Reconfiguration management reset, active high |
| ep_rst_o | output | 1 | Endpoint reset, active high |
| rp_rst_o | output | 1 | Root-port reset, active high |
| app_rst_o | output | 1 | Application-layer reset, active high |
| seq_done_o | output | 1 | High once every reset is released |
| seq_state_o | output | 3 | Current state: 0 idle, 1 calibration wait, 2 endpoint hold, 3 root-port released, 4 running |

## Verification
The bench holds one calibration flag high past the endpoint delay and then the other. A design that gated on only one flag, or on either flag, would release the endpoint too early. Configuration done is dropped partway through the endpoint wait and then raised again. This shows whether the shared counter restarts, because a design that kept the old count would release the endpoint ahead of the full delay. A busy flag is toggled after the endpoint release and the asynchronous reset is pulled in the running state. A design that did not latch its releases would glitch its outputs, and one that waited for a clock to reassert would show stale releases.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_CAL  = 3'd1,
    ST_EP   = 3'd2,
    ST_RP   = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/lrs_sync.sv
module lrs_sync #(
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= async_i[i];
        stab_q <= meta_q;
      end
    end

    assign sync_o[i] = stab_q;
  end

endmodule

// File: rtl/lrs_timer.sv
module lrs_timer #(
  parameter int unsigned EP_WAIT = 50_000,
  parameter int unsigned RP_WAIT = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic ep_hit_o,
  output logic rp_hit_o
);

  localparam int unsigned MAX_CNT = (EP_WAIT > RP_WAIT) ? EP_WAIT : RP_WAIT;
  localparam int          CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_CNT);
  localparam logic [CNT_W-1:0] EP_TOP  = CNT_W'(EP_WAIT);
  localparam logic [CNT_W-1:0] RP_TOP  = CNT_W'(RP_WAIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Saturating up-counter; clear has priority and restarts from zero.
  always_comb begin
    cnt_en = clr_i || (cnt_q != CNT_TOP);
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ep_hit_o = (cnt_q >= EP_TOP);
  assign rp_hit_o = (cnt_q >= RP_TOP);

  // R4: a clear always restarts the count from zero
  a_r4_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R5: the counter holds at its ceiling rather than wrapping
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_q == CNT_TOP) |=> (cnt_q == CNT_TOP));

endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
  import lrs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_s_i,
  input  logic               tx_busy_s_i,
  input  logic               rx_busy_s_i,
  input  logic               ep_hit_i,
  input  logic               rp_hit_i,
  output logic               tmr_clr_o,
  output logic               mgmt_rst_o,
  output logic               ep_rst_o,
  output logic               rp_rst_o,
  output logic               app_rst_o,
  output logic               done_o,
  output logic [STATE_W-1:0] state_o
);

  seq_state_e state_q;
  seq_state_e state_d;
  logic       state_en;
  logic       cal_clear;

  assign cal_clear = !tx_busy_s_i && !rx_busy_s_i;

  // Next-state logic. Loss of configuration overrides every other path.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cfg_s_i)               state_d = ST_CAL;
      ST_CAL:  if (ep_hit_i && cal_clear) state_d = ST_EP;
      ST_EP:   if (rp_hit_i)              state_d = ST_RP;
      ST_RP:                              state_d = ST_RUN;
      ST_RUN:                             state_d = ST_RUN;
      default:                            state_d = ST_IDLE;
    endcase
    if (!cfg_s_i) state_d = ST_IDLE;
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // The timer runs only in the two waiting states and restarts on entry to each.
  always_comb begin
    tmr_clr_o = !((state_q == ST_CAL) || (state_q == ST_EP))
                || ((state_q == ST_CAL) && (state_d == ST_EP));
  end

  // Output decode from the state register only (no combinational input path).
  always_comb begin
    mgmt_rst_o = (state_q == ST_IDLE);
    ep_rst_o   = (state_q == ST_IDLE) || (state_q == ST_CAL);
    rp_rst_o   = (state_q == ST_IDLE) || (state_q == ST_CAL) || (state_q == ST_EP);
    app_rst_o  = (state_q != ST_RUN);
    done_o     = (state_q == ST_RUN);
    state_o    = state_q;
  end

  // R2: management release only follows a seen configuration-done
  a_r2_mgmt_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mgmt_rst_o) |-> $past(cfg_s_i));

  // R3: endpoint release requires both calibration flags clear
  a_r3_cal_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ep_rst_o) |-> $past(cal_clear));

  // R4: endpoint release requires the minimum delay from the timer
  a_r4_ep_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ep_rst_o) |-> $past(ep_hit_i));

  // R5: root-port release needs the long delay and an already released endpoint
  a_r5_rp_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rp_rst_o) |-> ($past(rp_hit_i) && $past(!ep_rst_o)));

  // R6: application release comes after the root port
  a_r6_app_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(app_rst_o) |-> $past(!rp_rst_o));

  // R7: configuration loss reasserts everything on the next edge
  a_r7_cfg_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_s_i |=> (mgmt_rst_o && ep_rst_o && rp_rst_o && app_rst_o));

  // R9: a released endpoint stays released while configuration holds
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_rst_o && cfg_s_i) |=> !ep_rst_o);

endmodule

// File: rtl/link_reset_seq.sv
module link_reset_seq
  import lrs_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned EP_WAIT_CYC = CLK_FREQ_HZ / 1000,
  parameter int unsigned RP_WAIT_CYC = CLK_FREQ_HZ / 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_done_i,
  input  logic               tx_cal_busy_i,
  input  logic               rx_cal_busy_i,
  output logic               mgmt_rst_o,
  output logic               ep_rst_o,
  output logic               rp_rst_o,
  output logic               app_rst_o,
  output logic               seq_done_o,
  output logic [STATE_W-1:0] seq_state_o
);

  localparam int               N_SYNC   = 3;
  // Bit order {cfg, tx, rx}: configuration resets to absent, calibration to busy.
  localparam logic [N_SYNC-1:0] SYNC_RST = 3'b011;

  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] syn_in;
  logic              tmr_clr;
  logic              ep_hit;
  logic              rp_hit;

  assign raw_in = {cfg_done_i, tx_cal_busy_i, rx_cal_busy_i};

  lrs_sync #(
    .WIDTH   (N_SYNC),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (syn_in)
  );

  lrs_timer #(
    .EP_WAIT (EP_WAIT_CYC),
    .RP_WAIT (RP_WAIT_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tmr_clr),
    .ep_hit_o (ep_hit),
    .rp_hit_o (rp_hit)
  );

  lrs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_s_i     (syn_in[2]),
    .tx_busy_s_i (syn_in[1]),
    .rx_busy_s_i (syn_in[0]),
    .ep_hit_i    (ep_hit),
    .rp_hit_i    (rp_hit),
    .tmr_clr_o   (tmr_clr),
    .mgmt_rst_o  (mgmt_rst_o),
    .ep_rst_o    (ep_rst_o),
    .rp_rst_o    (rp_rst_o),
    .app_rst_o   (app_rst_o),
    .done_o      (seq_done_o),
    .state_o     (seq_state_o)
  );

endmodule

// File: tb/tb_link_reset_seq.sv
module tb_link_reset_seq;

  localparam int E = 20;
  localparam int R = 50;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_done_i, tx_cal_busy_i, rx_cal_busy_i;
  logic       mgmt_rst_o, ep_rst_o, rp_rst_o, app_rst_o, seq_done_o;
  logic [2:0] seq_state_o;

  link_reset_seq #(
    .CLK_FREQ_HZ (50_000_000),
    .EP_WAIT_CYC (E),
    .RP_WAIT_CYC (R)
  ) dut (
    .clk (clk), .rst_n (rst_n), .cfg_done_i (cfg_done_i),
    .tx_cal_busy_i (tx_cal_busy_i), .rx_cal_busy_i (rx_cal_busy_i),
    .mgmt_rst_o (mgmt_rst_o), .ep_rst_o (ep_rst_o), .rp_rst_o (rp_rst_o),
    .app_rst_o (app_rst_o), .seq_done_o (seq_done_o), .seq_state_o (seq_state_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  // Output vector order {mgmt, ep, rp, app, done}
  localparam logic [4:0] V_ALL  = 5'b11110;
  localparam logic [4:0] V_MGMT = 5'b01110;
  localparam logic [4:0] V_EP   = 5'b00110;
  localparam logic [4:0] V_RP   = 5'b00010;
  localparam logic [4:0] V_RUN  = 5'b00001;

  int         q_cyc[$];
  logic [4:0] q_vec[$];
  string      q_tag[$];
  logic [4:0] prev_vec = V_ALL;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [4:0] outv();
    return {mgmt_rst_o, ep_rst_o, rp_rst_o, app_rst_o, seq_done_o};
  endfunction

  task automatic expect_at(input int c, input logic [4:0] v, input string tag);
    q_cyc.push_back(c);
    q_vec.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check_now(input string tag, input logic [4:0] expv, input logic [2:0] exps);
    n_chk++;
    if (outv() !== expv || seq_state_o !== exps) begin
      n_fail++;
      $display("FAIL %s: outputs=%b state=%0d expected outputs=%b state=%0d",
               tag, outv(), seq_state_o, expv, exps);
    end
  endtask

  // Monitor: every output change is matched against the next expected event.
  always @(negedge clk) begin
    logic [4:0] v;
    v = outv();
    if (v !== prev_vec) begin
      n_chk++;
      if (q_cyc.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected change (R9): outputs=%b at cycle %0d expected=%b (no change)",
                 v, cyc, prev_vec);
      end else begin
        int         ec;
        logic [4:0] ev;
        string      et;
        ec = q_cyc.pop_front();
        ev = q_vec.pop_front();
        et = q_tag.pop_front();
        if (ec != cyc || ev !== v) begin
          n_fail++;
          $display("FAIL %s: outputs=%b at cycle %0d expected=%b at cycle %0d",
                   et, v, cyc, ev, ec);
        end
      end
      prev_vec = v;
    end
  end

  task automatic full_run(input string tag);
    int n;
    n = cyc;
    expect_at(n + 3,         V_MGMT, "R2");
    expect_at(n + E + 4,     V_EP,   "R4");
    expect_at(n + E + R + 5, V_RP,   "R5");
    expect_at(n + E + R + 6, V_RUN,  "R6");
    cfg_done_i = 1'b1;
    tick(E + R + 10);
    check_now({tag, " R6 running"}, V_RUN, 3'd4);
  endtask

  task automatic finish_run();
    if (ended) return;
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n, m;
    rst_n = 1'b0; cfg_done_i = 1'b0; tx_cal_busy_i = 1'b1; rx_cal_busy_i = 1'b1;
    tick(3);
    check_now("R1 in reset", V_ALL, 3'd0);
    rst_n = 1'b1;
    tick(6);
    check_now("R1 after reset, no config", V_ALL, 3'd0);

    // Both busy flags low up front: timer alone sets endpoint release (R4).
    tx_cal_busy_i = 1'b0; rx_cal_busy_i = 1'b0;
    tick(2);
    full_run("pass1");

    // R9: busy flags rising after release change nothing.
    tx_cal_busy_i = 1'b1; tick(4); rx_cal_busy_i = 1'b1; tick(8);
    check_now("R9 busy after release", V_RUN, 3'd4);
    tx_cal_busy_i = 1'b0; rx_cal_busy_i = 1'b0; tick(4);
    check_now("R9 busy cleared again", V_RUN, 3'd4);

    // R7: configuration loss from running.
    n = cyc; expect_at(n + 3, V_ALL, "R7");
    cfg_done_i = 1'b0; tick(6);
    check_now("R7 idle after loss", V_ALL, 3'd0);

    // R3: calibration holds endpoint past the delay; both flags must clear.
    tx_cal_busy_i = 1'b1; rx_cal_busy_i = 1'b0;
    n = cyc; expect_at(n + 3, V_MGMT, "R2");
    cfg_done_i = 1'b1;
    tick(E + 30);
    check_now("R3 tx busy holds endpoint", V_MGMT, 3'd1);
    rx_cal_busy_i = 1'b1; tick(2); tx_cal_busy_i = 1'b0; tick(10);
    check_now("R3 rx busy holds endpoint", V_MGMT, 3'd1);
    m = cyc;
    expect_at(m + 3,         V_EP,  "R3");
    expect_at(m + 3 + R + 1, V_RP,  "R5");
    expect_at(m + 3 + R + 2, V_RUN, "R6");
    rx_cal_busy_i = 1'b0;
    tick(R + 10);
    check_now("R6 running after cal", V_RUN, 3'd4);

    // R8: asynchronous reset in running state acts before any edge.
    @(negedge clk); #2;
    rst_n = 1'b0; #1;
    check_now("R8 async reset immediate", V_ALL, 3'd0);
    @(posedge clk); #2;
    n = cyc; expect_at(n, V_ALL, "R8");
    rst_n = 1'b1;  // config still high; restart occurs from idle
    expect_at(n + 3,         V_MGMT, "R2");
    expect_at(n + E + 4,     V_EP,   "R4");
    expect_at(n + E + R + 5, V_RP,   "R5");
    expect_at(n + E + R + 6, V_RUN,  "R6");
    tick(E + R + 10);
    check_now("R8 restart after reset", V_RUN, 3'd4);

    // R7: loss mid-wait restarts the endpoint delay from zero.
    n = cyc; expect_at(n + 3, V_ALL, "R7");
    cfg_done_i = 1'b0; tick(6);
    n = cyc; expect_at(n + 3, V_MGMT, "R2");
    cfg_done_i = 1'b1; tick(E / 2);
    check_now("R4 still waiting", V_MGMT, 3'd1);
    m = cyc; expect_at(m + 3, V_ALL, "R7");
    cfg_done_i = 1'b0; tick(6);
    check_now("R7 idle after mid-wait loss", V_ALL, 3'd0);
    full_run("pass-restart");

    tick(5);
    n_chk++;
    if (q_cyc.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d expected events missing, expected 0", q_tag[0], q_cyc.size());
    end
    finish_run();
  end

endmodule